// File: doc/BRIEF.md
# Countdown Timer with Sticky Event Status

This block is a processor-side countdown timer. A 32-bit down-counter steps by one on every timebase tick. When the count moves from one to zero, a sticky status flag is raised. If auto-reload is enabled, the counter is then refilled from a separate reload register. Otherwise it rests at zero until software writes a new value.

Two external event inputs, one for a watchdog and one for a fixed-interval timer, raise their own sticky flags. Each flag is cleared by writing a one to its position.

Three interrupt lines each follow the AND of one flag and one enable bit in the control register. Software reaches the control, status, count and reload registers through a single-cycle write port. A combinational read port shares the same address.

Top module: `dtmr_top`

## Requirements
- R1: After reset the control, status, count and reload registers read as zero and all three interrupt lines are low.
- R2: A write lands in the register selected by `reg_addr_i`: 0 control, 1 status, 2 count, 3 reload. Control, count and reload keep all 32 written bits. `reg_rdata_o` shows the selected register in the same cycle.
- R3: While the count is not zero, each cycle with `tick_i` high lowers it by one. Without a tick it holds.
- R4: A tick that takes the count from 1 to 0 sets status bit 27. The bit stays set until it is cleared.
- R5: With auto-reload off (control bit 22 = 0), a count of zero stays zero under further ticks and sets nothing more.
- R6: With control bit 22 = 1, a tick that would take the count from 1 to 0 loads the reload register instead. It still sets status bit 27.
- R7: A write to the status register clears exactly the status bits that are 1 in the written data and leaves the others. Only bits 26, 27 and 30 exist; other status bits read 0.
- R8: When a flag is set and cleared in the same cycle, it ends up set.
- R9: `irq_dec_o` equals status bit 27 AND control bit 26. A control write changes it from the next cycle.
- R10: `wdog_evt_i` sets status bit 30, and `irq_wdog_o` equals status bit 30 AND control bit 27.
- R11: `fit_evt_i` sets status bit 26, and `irq_fit_o` equals status bit 26 AND control bit 23.
- R12: A count write in the same cycle as a tick wins. The written value is loaded and no expiry is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase tick, one count step per high cycle |
| wdog_evt_i | input | 1 | Watchdog event, sets its status flag |
| fit_evt_i | input | 1 | Fixed-interval event, sets its status flag |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select for write and read |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| irq_dec_o | output | 1 | Countdown interrupt |
| irq_wdog_o | output | 1 | Watchdog interrupt |
| irq_fit_o | output | 1 | Fixed-interval interrupt |

## Verification
A wrong count shows up on the count readback one cycle after the tick that caused it. It also skews the expiry: the status flag and the countdown interrupt rise early, late or not at all. A status flag that fails to stick, or that clears the wrong bit, is visible the cycle after the write, both on the status readback and on the interrupt it gates. The bench reads a register every cycle and compares all three interrupt lines every cycle, so a divergence shows within one clock.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

  typedef enum logic [1:0] {
    RA_CTRL   = 2'd0,
    RA_STAT   = 2'd1,
    RA_COUNT  = 2'd2,
    RA_RELOAD = 2'd3
  } reg_addr_e;

  // status flag positions
  localparam int unsigned ST_FIX = 26;
  localparam int unsigned ST_DEC = 27;
  localparam int unsigned ST_WDG = 30;
  // control bit positions
  localparam int unsigned CT_AUTO  = 22;
  localparam int unsigned CT_FIXEN = 23;
  localparam int unsigned CT_DECEN = 26;
  localparam int unsigned CT_WDGEN = 27;

  // sticky update: clear first, then set, so a set wins
  function automatic logic [31:0] sticky_next(input logic [31:0] cur,
                                              input logic [31:0] set_v,
                                              input logic [31:0] clr_v,
                                              input logic [31:0] keep);
    return ((cur & ~clr_v) | set_v) & keep;
  endfunction

  // value the counter takes after a tick from a non-zero count
  function automatic logic [31:0] step_down(input logic [31:0] cur,
                                            input logic [31:0] refill,
                                            input logic        auto_en);
    if (cur == 32'd1) return auto_en ? refill : 32'd0;
    return cur - 32'd1;
  endfunction

endpackage

// File: rtl/dtmr_count.sv
module dtmr_count
  import dtmr_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic [DW-1:0] refill_i,
  input  logic          auto_i,
  output logic [DW-1:0] cnt_o,
  output logic          expire_o
);

  logic [DW-1:0] cnt_q;
  logic          at_one_w;
  logic          live_w;

  assign at_one_w = (cnt_q == DW'(1));
  assign live_w   = (cnt_q != '0);
  assign expire_o = tick_i && !load_i && at_one_w;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (tick_i && live_w) begin
      cnt_q <= DW'(step_down(32'(cnt_q), 32'(refill_i), auto_i));
    end
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i && cnt_q > DW'(1)) |=> (cnt_q == $past(cnt_q) - DW'(1)));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q));
  p_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
  p_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && auto_i) |=> (cnt_q == $past(refill_i)));
  p_load_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/dtmr_status.sv
module dtmr_status
  import dtmr_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_i,
  input  logic          clr_en_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] st_o
);

  localparam logic [DW-1:0] KEEP =
    DW'((32'd1 << ST_FIX) | (32'd1 << ST_DEC) | (32'd1 << ST_WDG));

  logic [DW-1:0] st_q;
  logic [DW-1:0] clr_w;

  assign clr_w = clr_en_i ? clr_i : '0;
  assign st_o  = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= DW'(sticky_next(32'(st_q), 32'(set_i), 32'(clr_w), 32'(KEEP)));
  end

  p_dec_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[ST_DEC] && !(clr_en_i && clr_i[ST_DEC])) |=> st_q[ST_DEC]);
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && clr_i[ST_WDG] && !set_i[ST_WDG]) |=> !st_q[ST_WDG]);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i[ST_FIX] && clr_en_i && clr_i[ST_FIX]) |=> st_q[ST_FIX]);

endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
  import dtmr_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wdog_evt_i,
  input  logic          fit_evt_i,
  input  logic          reg_wr_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_dec_o,
  output logic          irq_wdog_o,
  output logic          irq_fit_o
);

  logic [DW-1:0] ctl_q, refill_q, cnt_w, st_w, set_w;
  logic          ctl_wr, st_wr, cnt_wr, rel_wr, dec_expire;

  assign ctl_wr = reg_wr_i && (reg_addr_i == RA_CTRL);
  assign st_wr  = reg_wr_i && (reg_addr_i == RA_STAT);
  assign cnt_wr = reg_wr_i && (reg_addr_i == RA_COUNT);
  assign rel_wr = reg_wr_i && (reg_addr_i == RA_RELOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      refill_q <= '0;
    end else begin
      if (ctl_wr) ctl_q    <= reg_wdata_i;
      if (rel_wr) refill_q <= reg_wdata_i;
    end
  end

  dtmr_count #(.DW(DW)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .load_i    (cnt_wr),
    .load_val_i(reg_wdata_i),
    .refill_i  (refill_q),
    .auto_i    (ctl_q[CT_AUTO]),
    .cnt_o     (cnt_w),
    .expire_o  (dec_expire)
  );

  always_comb begin
    set_w         = '0;
    set_w[ST_DEC] = dec_expire;
    set_w[ST_WDG] = wdog_evt_i;
    set_w[ST_FIX] = fit_evt_i;
  end

  dtmr_status #(.DW(DW)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_w),
    .clr_en_i(st_wr),
    .clr_i   (reg_wdata_i),
    .st_o    (st_w)
  );

  assign irq_dec_o  = st_w[ST_DEC] & ctl_q[CT_DECEN];
  assign irq_wdog_o = st_w[ST_WDG] & ctl_q[CT_WDGEN];
  assign irq_fit_o  = st_w[ST_FIX] & ctl_q[CT_FIXEN];

  always_comb begin
    unique case (reg_addr_i)
      RA_CTRL:  reg_rdata_o = ctl_q;
      RA_STAT:  reg_rdata_o = st_w;
      RA_COUNT: reg_rdata_o = cnt_w;
      default:  reg_rdata_o = refill_q;
    endcase
  end

  p_dec_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_expire && ctl_q[CT_DECEN] && !ctl_wr) |=> irq_dec_o);
  p_dec_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !reg_wdata_i[CT_DECEN]) |=> !irq_dec_o);
  p_wdog_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_evt_i && ctl_q[CT_WDGEN] && !ctl_wr) |=> irq_wdog_o);
  p_fit_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fit_evt_i && ctl_q[CT_FIXEN] && !ctl_wr) |=> irq_fit_o);
  p_no_expire_on_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |-> !dec_expire);

endmodule

// File: tb/test_dtmr_top.sv
module test_dtmr_top;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, wdog_evt_i = 1'b0, fit_evt_i = 1'b0, reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_dec_o, irq_wdog_o, irq_fit_o;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic [31:0] m_ctl = '0, m_st = '0, m_cnt = '0, m_rel = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtmr_top i_dtmr_top (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wdog_evt_i(wdog_evt_i),
    .fit_evt_i(fit_evt_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .irq_dec_o(irq_dec_o), .irq_wdog_o(irq_wdog_o), .irq_fit_o(irq_fit_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_ctl;
      2'd1: return m_st;
      2'd2: return m_cnt;
      default: return m_rel;
    endcase
  endfunction

  // one clock: drive, advance the model, compare after the edge
  task automatic cyc(input logic tk, input logic wr, input logic [1:0] ad,
                     input logic [31:0] d, input logic we, input logic fe,
                     input string tag);
    logic [31:0] n_st, clr;
    bit hit;
    tick_i = tk; reg_wr_i = wr; reg_addr_i = ad; reg_wdata_i = d;
    wdog_evt_i = we; fit_evt_i = fe;
    clr = (wr && ad == 2'd1) ? d : 32'h0;
    hit = tk && !(wr && ad == 2'd2) && (m_cnt == 1);
    n_st = m_st;
    for (int b = 0; b < 32; b++) if (clr[b]) n_st[b] = 1'b0;
    if (hit) n_st[27] = 1'b1;
    if (we)  n_st[30] = 1'b1;
    if (fe)  n_st[26] = 1'b1;
    n_st = n_st & 32'h4C00_0000;
    if (wr && ad == 2'd2)      m_cnt = d;
    else if (tk && m_cnt != 0) m_cnt = (m_cnt == 1) ? (m_ctl[22] ? m_rel : 0) : m_cnt - 1;
    if (wr && ad == 2'd0) m_ctl = d;
    if (wr && ad == 2'd3) m_rel = d;
    m_st = n_st;
    @(posedge clk);
    @(negedge clk);
    check(tag, reg_rdata_o, m_read(ad));
    check("R9 irq_dec", {31'd0, irq_dec_o}, {31'd0, m_st[27] & m_ctl[26]});
    check("R10 irq_wdog", {31'd0, irq_wdog_o}, {31'd0, m_st[30] & m_ctl[27]});
    check("R11 irq_fit", {31'd0, irq_fit_o}, {31'd0, m_st[26] & m_ctl[23]});
    tick_i = 0; reg_wr_i = 0; wdog_evt_i = 0; fit_evt_i = 0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    for (int a = 0; a < 4; a++) cyc(0, 0, 2'(a), 0, 0, 0, "R1 reset value");
    // R2 register access
    cyc(0, 1, 2'd3, 32'hA5A5_0007, 0, 0, "R2 reload write");
    cyc(0, 1, 2'd0, 32'h0400_0000, 0, 0, "R2 control write");   // countdown irq enable
    cyc(0, 1, 2'd2, 32'd3, 0, 0, "R2 count write");
    // R3 countdown and hold
    cyc(1, 0, 2'd2, 0, 0, 0, "R3 tick step");
    cyc(0, 0, 2'd2, 0, 0, 0, "R3 hold without tick");
    cyc(1, 0, 2'd2, 0, 0, 0, "R3 tick step");
    cyc(1, 0, 2'd2, 0, 0, 0, "R4 expiry count");
    cyc(0, 0, 2'd1, 0, 0, 0, "R4 status bit 27 set");
    // R5 rest at zero
    cyc(1, 0, 2'd2, 0, 0, 0, "R5 stays zero");
    cyc(1, 0, 2'd1, 0, 0, 0, "R4 sticky status");
    // R7 W1C: set other flags, clear only one
    cyc(0, 1, 2'd0, 32'h0C80_0000, 1, 1, "R10 R11 enables and events");
    cyc(0, 1, 2'd1, 32'h0400_0000, 0, 0, "R7 clear fixed flag only");
    cyc(0, 1, 2'd1, 32'hB3FF_FFFF, 0, 0, "R7 clear nothing flagged");
    cyc(0, 1, 2'd1, 32'hFFFF_FFFF, 0, 0, "R7 clear all");
    // R6 auto-reload
    cyc(0, 1, 2'd0, 32'h0440_0000, 0, 0, "R6 enable auto reload");
    cyc(0, 1, 2'd3, 32'd4, 0, 0, "R6 reload value");
    cyc(0, 1, 2'd2, 32'd2, 0, 0, "R6 count value");
    for (int i = 0; i < 11; i++) cyc(1, 0, 2'd2, 0, 0, 0, "R6 refill sequence");
    cyc(0, 0, 2'd1, 0, 0, 0, "R6 status after refill");
    // R8 set wins over clear
    cyc(0, 1, 2'd1, 32'hFFFF_FFFF, 0, 0, "R7 clear all");
    cyc(0, 1, 2'd2, 32'd1, 0, 0, "R8 prime count");
    cyc(1, 1, 2'd1, 32'h0800_0000, 0, 0, "R8 expiry beats clear");
    cyc(0, 1, 2'd1, 32'h0400_0000, 0, 1, "R8 fixed event beats clear");
    cyc(0, 1, 2'd1, 32'hFFFF_FFFF, 0, 0, "R7 clear all");
    // R12 count write wins over tick
    cyc(0, 1, 2'd2, 32'd1, 0, 0, "R12 prime count");
    cyc(1, 1, 2'd2, 32'd7, 0, 0, "R12 write beats tick");
    cyc(0, 0, 2'd1, 0, 0, 0, "R12 no expiry flagged");
    // R9 enable change takes effect next cycle
    cyc(0, 1, 2'd2, 32'd1, 0, 0, "R9 prime count");
    cyc(1, 0, 2'd1, 0, 0, 0, "R9 expiry raises irq");
    cyc(0, 1, 2'd0, 32'h0000_0000, 0, 0, "R9 disable enable");
    cyc(0, 1, 2'd0, 32'h0400_0000, 0, 0, "R9 re-enable");
    cyc(0, 0, 2'd1, 0, 1, 0, "R10 watchdog event no enable");
    cyc(0, 0, 2'd3, 0, 0, 0, "R2 reload readback");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule